// File: doc/BRIEF.md
# Interrupt Cycle Controller

This block runs next to a processor's instruction sequencer. It decides whether the next instruction cycle is an ordinary fetch or an interrupt cycle. It holds two flags: a global interrupt-enable flag, and a pending-request flag that marks an interrupt cycle in progress. Software sets and clears the enable flag through two strobes. Device ready flags, one per attached device, raise the request.

The request is sampled only while the sequencer is past its fetch steps. Once it is latched, the next three sequencer steps form the interrupt cycle instead of a fetch:

- Step 0: the address register is cleared and the temporary register takes the program counter.
- Step 1: the temporary register is written to memory word 0, and the program counter is cleared.
- Step 2: the program counter is incremented to 1, both flags are cleared and the step counter is cleared.

Execution therefore resumes at address 1 with the return address saved at word 0. The block produces only control strobes; the datapath registers live in the neighbouring sequencer and datapath.

Top module: `irq_cycle_ctrl`

## Requirements
- R1: While reset is asserted (rst_n low), irq_active and int_enabled are 0. With irq_active 0, every datapath strobe (ar_clr, tr_load_pc, mem_wr, pc_clr, pc_inc, sc_clr) is 0 and fetch_go is 1.
- R2: At a clock edge where seq_step is 3 or more, int_enabled is 1, irq_active is 0 and at least one dev_ready bit is 1, irq_active becomes 1.
- R3: irq_active is not set at an edge where seq_step is 0, 1 or 2, where int_enabled is 0, or where no dev_ready bit is 1.
- R4: While irq_active is 1 and seq_step is 0, ar_clr and tr_load_pc are 1 and the other datapath strobes are 0.
- R5: While irq_active is 1 and seq_step is 1, mem_wr and pc_clr are 1 and the other datapath strobes are 0.
- R6: While irq_active is 1 and seq_step is 2, pc_inc and sc_clr are 1. After that edge, irq_active and int_enabled are both 0.
- R7: fetch_go is 1 exactly when irq_active is 0. While irq_active is 0, no datapath strobe is asserted for any seq_step.
- R8: ien_on sets int_enabled at the next edge, and ien_off clears it. When both are 1, ien_off wins. The clear at the end of an interrupt cycle (R6) wins over ien_on.
- R9: The request decision at an edge uses int_enabled as it was before that edge. An ien_on in the same cycle cannot set irq_active until a later eligible edge.
- R10: While irq_active is 1 and seq_step is 3 or more, irq_active stays 1 and no datapath strobe is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| seq_step | input | SC_W (4) | Current sequencer timing step |
| dev_ready | input | N_SRC (2) | Device ready flags |
| ien_on | input | 1 | Strobe that enables interrupts |
| ien_off | input | 1 | Strobe that disables interrupts |
| irq_active | output | 1 | Request flag; interrupt cycle in progress |
| int_enabled | output | 1 | Interrupt-enable flag |
| fetch_go | output | 1 | Ordinary fetch may proceed |
| ar_clr | output | 1 | Clear address register |
| tr_load_pc | output | 1 | Load temporary register from program counter |
| mem_wr | output | 1 | Write temporary register to memory at address register |
| pc_clr | output | 1 | Clear program counter |
| pc_inc | output | 1 | Increment program counter |
| sc_clr | output | 1 | Clear sequencer step counter |

## Verification
Random steps, ready patterns and enable strobes are compared every cycle against a reference model in the bench. The random mix separates a request raised during fetch steps from one raised after them, and a single ready source from both sources. Directed sequences cover the following cases:
- a full three-step interrupt cycle, checking the strobes on each step;
- ien_on arriving in the same cycle as a ready flag, which tells a registered enable decision from a bypassed one;
- ien_on and ien_off together, which fixes the priority between them;
- ien_on during the final interrupt step, which shows the end-of-cycle clear winning.

// File: rtl/irq_cycle_pkg.sv
package irq_cycle_pkg;
  localparam int unsigned CYC_STEPS = 3;

  typedef enum logic [1:0] {
    STEP_SAVE  = 2'd0,
    STEP_STORE = 2'd1,
    STEP_ENTER = 2'd2
  } irq_step_e;

  typedef struct packed {
    logic ar_clr;
    logic tr_load_pc;
    logic mem_wr;
    logic pc_clr;
    logic pc_inc;
    logic sc_clr;
  } irq_strobes_t;
endpackage

// File: rtl/irq_step_decode.sv
module irq_step_decode #(
  parameter int unsigned SC_W = 4
) (
  input  logic [SC_W-1:0]                         seq_step,
  output logic [irq_cycle_pkg::CYC_STEPS-1:0]     step_hot,
  output logic                                    past_fetch
);
  localparam int unsigned NSTEP = irq_cycle_pkg::CYC_STEPS;

  for (genvar i = 0; i < NSTEP; i++) begin : g_step
    assign step_hot[i] = (seq_step == SC_W'(i));
  end

  always_comb begin
    past_fetch = ~(|step_hot);
  end
endmodule

// File: rtl/irq_enable_flag.sv
module irq_enable_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_req,
  input  logic clr_req,
  input  logic cycle_end,
  output logic en_q
);
  logic en_d;

  always_comb begin
    en_d = en_q;
    if (cycle_end)    en_d = 1'b0;
    else if (clr_req) en_d = 1'b0;
    else if (set_req) en_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= en_d;
  end
endmodule

// File: rtl/irq_request_latch.sv
module irq_request_latch #(
  parameter int unsigned N_SRC = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] dev_ready,
  input  logic             en_q,
  input  logic             past_fetch,
  input  logic             cycle_end,
  output logic             req_q
);
  logic any_ready;
  logic set_ok;
  logic req_d;

  always_comb begin
    any_ready = |dev_ready;
    set_ok    = past_fetch & en_q & any_ready;
    req_d     = req_q;
    if (req_q && cycle_end) req_d = 1'b0;
    else if (set_ok)        req_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= req_d;
  end
endmodule

// File: rtl/irq_strobe_gen.sv
module irq_strobe_gen
  import irq_cycle_pkg::*;
(
  input  logic                 req_q,
  input  logic [CYC_STEPS-1:0] step_hot,
  output irq_strobes_t         strb,
  output logic                 cycle_end
);
  always_comb begin
    strb            = '0;
    strb.ar_clr     = req_q & step_hot[STEP_SAVE];
    strb.tr_load_pc = req_q & step_hot[STEP_SAVE];
    strb.mem_wr     = req_q & step_hot[STEP_STORE];
    strb.pc_clr     = req_q & step_hot[STEP_STORE];
    strb.pc_inc     = req_q & step_hot[STEP_ENTER];
    strb.sc_clr     = req_q & step_hot[STEP_ENTER];
    cycle_end       = req_q & step_hot[STEP_ENTER];
  end
endmodule

// File: rtl/irq_cycle_ctrl.sv
module irq_cycle_ctrl
  import irq_cycle_pkg::*;
#(
  parameter int unsigned SC_W  = 4,
  parameter int unsigned N_SRC = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SC_W-1:0]  seq_step,
  input  logic [N_SRC-1:0] dev_ready,
  input  logic             ien_on,
  input  logic             ien_off,
  output logic             irq_active,
  output logic             int_enabled,
  output logic             fetch_go,
  output logic             ar_clr,
  output logic             tr_load_pc,
  output logic             mem_wr,
  output logic             pc_clr,
  output logic             pc_inc,
  output logic             sc_clr
);
  logic [CYC_STEPS-1:0] step_hot;
  logic                 past_fetch;
  logic                 cycle_end;
  logic                 en_q;
  logic                 req_q;
  irq_strobes_t         strb;

  irq_step_decode #(.SC_W(SC_W)) u_dec (
    .seq_step   (seq_step),
    .step_hot   (step_hot),
    .past_fetch (past_fetch)
  );

  irq_enable_flag u_en (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_req   (ien_on),
    .clr_req   (ien_off),
    .cycle_end (cycle_end),
    .en_q      (en_q)
  );

  irq_request_latch #(.N_SRC(N_SRC)) u_req (
    .clk        (clk),
    .rst_n      (rst_n),
    .dev_ready  (dev_ready),
    .en_q       (en_q),
    .past_fetch (past_fetch),
    .cycle_end  (cycle_end),
    .req_q      (req_q)
  );

  irq_strobe_gen u_strb (
    .req_q     (req_q),
    .step_hot  (step_hot),
    .strb      (strb),
    .cycle_end (cycle_end)
  );

  assign irq_active  = req_q;
  assign int_enabled = en_q;
  assign fetch_go    = ~req_q;
  assign ar_clr      = strb.ar_clr;
  assign tr_load_pc  = strb.tr_load_pc;
  assign mem_wr      = strb.mem_wr;
  assign pc_clr      = strb.pc_clr;
  assign pc_inc      = strb.pc_inc;
  assign sc_clr      = strb.sc_clr;
endmodule

// File: rtl/irq_cycle_ctrl_chk.sv
module irq_cycle_ctrl_chk #(
  parameter int unsigned SC_W  = 4,
  parameter int unsigned N_SRC = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic [SC_W-1:0]  seq_step,
  input logic [N_SRC-1:0] dev_ready,
  input logic             ien_on,
  input logic             ien_off,
  input logic             irq_active,
  input logic             int_enabled,
  input logic             ar_clr,
  input logic             mem_wr,
  input logic             pc_inc,
  input logic             sc_clr
);
  // R2
  req_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_active && int_enabled && (|dev_ready) && seq_step >= SC_W'(3)) |=> irq_active);
  // R3
  no_raise_in_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_active && seq_step < SC_W'(3)) |=> !irq_active);
  // R3
  no_raise_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_active && !int_enabled) |=> !irq_active);
  // R4
  step_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ar_clr, mem_wr, pc_inc}));
  // R6
  cycle_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_active && sc_clr) |=> (!irq_active && !int_enabled));
  // R7
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_active |-> !(ar_clr || mem_wr || pc_inc || sc_clr));
  // R8
  ien_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ien_on && !ien_off && !sc_clr) |=> int_enabled);
  // R8
  ien_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ien_off |=> !int_enabled);
  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_active && seq_step >= SC_W'(3)) |=> irq_active);
endmodule

bind irq_cycle_ctrl irq_cycle_ctrl_chk #(.SC_W(SC_W), .N_SRC(N_SRC)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .seq_step    (seq_step),
  .dev_ready   (dev_ready),
  .ien_on      (ien_on),
  .ien_off     (ien_off),
  .irq_active  (irq_active),
  .int_enabled (int_enabled),
  .ar_clr      (ar_clr),
  .mem_wr      (mem_wr),
  .pc_inc      (pc_inc),
  .sc_clr      (sc_clr)
);

// File: tb/irq_cycle_ctrl_test.sv
`timescale 1ns/1ps
module irq_cycle_ctrl_test;
  localparam int SC_W  = 4;
  localparam int N_SRC = 2;

  logic             clk;
  logic             rst_n;
  logic [SC_W-1:0]  seq_step;
  logic [N_SRC-1:0] dev_ready;
  logic             ien_on, ien_off;
  logic irq_active, int_enabled, fetch_go;
  logic ar_clr, tr_load_pc, mem_wr, pc_clr, pc_inc, sc_clr;

  int errors = 0;
  int checks = 0;
  bit m_req, m_en;

  irq_cycle_ctrl #(.SC_W(SC_W), .N_SRC(N_SRC)) uut (
    .clk(clk), .rst_n(rst_n), .seq_step(seq_step), .dev_ready(dev_ready),
    .ien_on(ien_on), .ien_off(ien_off), .irq_active(irq_active),
    .int_enabled(int_enabled), .fetch_go(fetch_go), .ar_clr(ar_clr),
    .tr_load_pc(tr_load_pc), .mem_wr(mem_wr), .pc_clr(pc_clr),
    .pc_inc(pc_inc), .sc_clr(sc_clr)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // expected strobe vector {fetch_go, ar_clr, tr_load_pc, mem_wr, pc_clr, pc_inc, sc_clr}
  function automatic logic [6:0] exp_strobes(bit req, int step);
    logic [6:0] v;
    v = 7'b1000000;
    if (req) begin
      v = 7'b0000000;
      if (step == 0) v = 7'b0110000;
      if (step == 1) v = 7'b0001100;
      if (step == 2) v = 7'b0000011;
    end
    return v;
  endfunction

  function automatic bit exp_req(bit req, bit en, int step, logic [N_SRC-1:0] rdy);
    if (req) return !(step == 2);
    return (step >= 3) && en && (|rdy);
  endfunction

  function automatic bit exp_en(bit req, bit en, int step, bit on, bit off);
    if (req && step == 2) return 1'b0;
    if (off) return 1'b0;
    if (on)  return 1'b1;
    return en;
  endfunction

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  // one cycle: drive at negedge, check strobes, clock, check flags
  task automatic cycle(int step, logic [N_SRC-1:0] rdy, bit on, bit off, string tag);
    bit nr, ne;
    seq_step  = SC_W'(step);
    dev_ready = rdy;
    ien_on    = on;
    ien_off   = off;
    #1;
    check({tag, " strobes R4 R5 R7"},
          {1'b0, fetch_go, ar_clr, tr_load_pc, mem_wr, pc_clr, pc_inc, sc_clr},
          {1'b0, exp_strobes(m_req, step)});
    nr = exp_req(m_req, m_en, step, rdy);
    ne = exp_en(m_req, m_en, step, on, off);
    @(posedge clk);
    m_req = nr;
    m_en  = ne;
    @(negedge clk);
    check({tag, " flags R2 R3 R6 R8"}, {6'b0, irq_active, int_enabled}, {6'b0, m_req, m_en});
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    rst_n = 1'b0; seq_step = '0; dev_ready = '0; ien_on = 0; ien_off = 0;
    m_req = 0; m_en = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 reset", {1'b0, irq_active, int_enabled, fetch_go, ar_clr, mem_wr, pc_inc, sc_clr},
          8'b00010000);
    rst_n = 1'b1;
    @(negedge clk);

    // R3: ready while disabled
    cycle(5, 2'b11, 0, 0, "R3 disabled");
    // R9: ion in same cycle as ready past fetch; R stays 0 that edge
    cycle(4, 2'b01, 1, 0, "R9 same-cycle ion");
    // R3: enabled, ready, but fetch steps
    cycle(0, 2'b10, 0, 0, "R3 step0");
    cycle(1, 2'b10, 0, 0, "R3 step1");
    cycle(2, 2'b11, 0, 0, "R3 step2");
    // R3: no ready
    cycle(7, 2'b00, 0, 0, "R3 no ready");
    // R2: raise
    cycle(3, 2'b10, 0, 0, "R2 raise");
    // R10 hold
    cycle(9, 2'b00, 0, 0, "R10 hold");
    // R4 R5 R6 sequence, ion at final step loses (R8)
    cycle(0, 2'b00, 0, 0, "R4 save");
    cycle(1, 2'b00, 0, 0, "R5 store");
    cycle(2, 2'b11, 1, 0, "R6 enter");
    // R8: both strobes, off wins
    cycle(6, 2'b00, 1, 1, "R8 both");
    cycle(6, 2'b00, 1, 0, "R8 on");
    cycle(6, 2'b00, 0, 1, "R8 off");

    // random mix
    for (int i = 0; i < 3000; i++) begin
      int st;
      st = (($urandom % 4) == 0) ? int'($urandom % 16) : int'($urandom % 4);
      cycle(st, N_SRC'($urandom), ($urandom % 5) == 0, ($urandom % 11) == 0, "rand");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule